// File: doc/BRIEF.md
# Byte-Serial Signed Multiply-Accumulate Engine

This block multiplies two signed 16-bit operands and either loads the product into an accumulator or adds it to the value already held there. It uses a single 8-bit by 8-bit multiplier. Each 16x16 product is built from four byte-pair partial products over four clock cycles. For each byte pair the multiplier is set to unsigned, signed or mixed-sign mode, and the result is shifted into place. The accumulator is a whole number of byte lanes, set by a parameter. Three lanes (24 bits) is enough for one product whose operands stay clear of full range. Five lanes (40 bits) leaves headroom for long sums of full-range products.

A filter sequencer drives the block. It pulses `start` with the two operands and a mode bit. In multiply-only mode the accumulator is replaced with the new product, which starts a new sum. In accumulate mode the product is added to the running total. `busy` stays high while the four partial products are formed. `done` pulses once after the last addition. A synchronous `clear` zeroes the accumulator at any time. If the sum grows past the accumulator width it wraps in two's complement and does not saturate.

Top module: `byte_serial_mac`

## Requirements
- R1: With `accumMode`=0 (multiply-only), the accumulator after `done` holds `opA*opB` as a signed product, truncated to ACC_W bits. The previous contents are discarded.
- R2: With `accumMode`=1 (accumulate), the accumulator after `done` holds the previous value plus `opA*opB`, modulo 2^ACC_W.
- R3: A `start` taken while `busy` is low raises `busy` in the next cycle. `busy` then stays high for exactly 4 cycles. `done` is high for exactly one cycle: the cycle after the last `busy` cycle, when `busy` is already low.
- R4: A `start` raised while `busy` is high is ignored. Its operands and mode are not used, and no further operation follows.
- R5: `clear`=1 at a clock edge makes the accumulator read zero after that edge. This takes priority over a partial-product addition due at the same edge, which is dropped. The later partial products of an operation in flight are still added.
- R6: When a sum passes the signed ACC_W range, the accumulator wraps modulo 2^ACC_W and never saturates.
- R7: While `busy` is low and `clear` is low, the accumulator holds its value.
- R8: The most negative operands are handled exactly. For example, -32768 x -32768 gives 2^30, and -32768 x 32767 gives -1073709056.
- R9: Partial products are added in a fixed order, one per busy cycle. The order is:
  1. Low byte x low byte, unsigned x unsigned, shift 0.
  2. High byte of `opA` (signed) x low byte of `opB` (unsigned), shift 8.
  3. High byte of `opB` (signed) x low byte of `opA` (unsigned), shift 8.
  4. High byte x high byte, signed x signed, shift 16.

  Each partial product is sign-extended before it is added. The accumulator shows each running sum one cycle after the corresponding busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; zeroes accumulator and control |
| start | input | 1 | Begins an operation when `busy` is low |
| accumMode | input | 1 | 0 = multiply-only (replace), 1 = multiply-accumulate |
| opA | input | 16 | Signed multiplicand, captured with `start` |
| opB | input | 16 | Signed multiplier, captured with `start` |
| clear | input | 1 | Synchronous accumulator clear, highest priority |
| busy | output | 1 | High during the four partial-product cycles |
| done | output | 1 | One-cycle pulse after the final addition |
| acc | output | ACC_W | Accumulator contents (ACC_W = 8*ACC_BYTES) |

## Verification
Two functions can fall in the same clock edge. The clear can coincide with the final partial-product addition, and it can coincide with an accepted start. The bench raises `clear` in the cycle before the fourth step. It then expects the accumulator to read zero while `done` still pulses on time. The bench also raises `clear` together with `start` in accumulate mode. There it expects the result to equal the bare product, with no earlier total carried in.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  // Number of byte-pair partial products per 16x16 operation
  localparam int STEPS = 4;
  localparam int STEP_W = 2;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic              capture;   // latch operands and mode
    logic              stepValid; // add one partial product this cycle
    logic [STEP_W-1:0] stepIdx;   // which byte pair
  } ctrlStrobes_t;

endpackage

// File: rtl/bsmac_mul8.sv
module bsmac_mul8 (
  input  logic              aSigned,
  input  logic              bSigned,
  input  logic [7:0]        aByte,
  input  logic [7:0]        bByte,
  output logic signed [16:0] prod
);

  logic signed [8:0]  aExt;
  logic signed [8:0]  bExt;
  logic signed [17:0] full;

  always_comb begin
    aExt = {aSigned & aByte[7], aByte};
    bExt = {bSigned & bByte[7], bByte};
    full = aExt * bExt;
    prod = full[16:0];
  end

endmodule

// File: rtl/bsmac_lane_adder.sv
module bsmac_lane_adder #(
  parameter int LANES = 5,
  localparam int W = LANES * 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);

  // Byte lanes chained through a ripple carry; carry out of the top lane dropped (wrap)
  logic [LANES-1:0][7:0] xLane;
  logic [LANES-1:0][7:0] yLane;
  logic [LANES-1:0][7:0] sLane;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign xLane[g] = x[g*8 +: 8];
    assign yLane[g] = y[g*8 +: 8];
    assign sum[g*8 +: 8] = sLane[g];
  end

  always_comb begin
    logic carry;
    logic [8:0] part;
    carry = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      part = {1'b0, xLane[i]} + {1'b0, yLane[i]} + {8'd0, carry};
      sLane[i] = part[7:0];
      carry = part[8];
    end
  end

endmodule

// File: rtl/bsmac_ctrl.sv
module bsmac_ctrl
  import bsmac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  logic              busyQ;
  logic [STEP_W-1:0] stepQ;
  logic              doneQ;
  logic              lastStep;

  assign lastStep = busyQ && (stepQ == STEP_W'(STEPS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      stepQ <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= lastStep;
      if (!busyQ) begin
        if (start) begin
          busyQ <= 1'b1;
          stepQ <= '0;
        end
      end else begin
        stepQ <= stepQ + 1'b1;
        if (lastStep) busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.capture   = start && !busyQ;
    strobes.stepValid = busyQ;
    strobes.stepIdx   = stepQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/bsmac_dpath.sv
module bsmac_dpath
  import bsmac_pkg::*;
#(
  parameter int ACC_BYTES = 5,
  localparam int ACC_W = ACC_BYTES * 8,
  localparam int EXT_W = (ACC_W > 33) ? ACC_W : 33
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             accumMode,
  input  logic [15:0]      opA,
  input  logic [15:0]      opB,
  input  logic             clear,
  output logic [ACC_W-1:0] acc
);

  logic [15:0]        regA;
  logic [15:0]        regB;
  logic               modeQ;
  logic [7:0]         mulA;
  logic [7:0]         mulB;
  logic               mulASgn;
  logic               mulBSgn;
  logic [4:0]         shiftAmt;
  logic signed [16:0] prod;
  logic [EXT_W-1:0]   ppExt;
  logic [EXT_W-1:0]   ppShift;
  logic [ACC_W-1:0]   addend;
  logic [ACC_W-1:0]   sumOut;
  logic [ACC_W-1:0]   accQ;
  logic               replace;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA  <= '0;
      regB  <= '0;
      modeQ <= 1'b0;
    end else if (strobes.capture) begin
      regA  <= opA;
      regB  <= opB;
      modeQ <= accumMode;
    end
  end

  // Byte-pair selection and multiplier mode per step
  always_comb begin
    case (strobes.stepIdx)
      2'd0: begin
        mulA = regA[7:0];  mulASgn = 1'b0;
        mulB = regB[7:0];  mulBSgn = 1'b0;
        shiftAmt = 5'd0;
      end
      2'd1: begin
        mulA = regA[15:8]; mulASgn = 1'b1;
        mulB = regB[7:0];  mulBSgn = 1'b0;
        shiftAmt = 5'd8;
      end
      2'd2: begin
        mulA = regB[15:8]; mulASgn = 1'b1;
        mulB = regA[7:0];  mulBSgn = 1'b0;
        shiftAmt = 5'd8;
      end
      default: begin
        mulA = regA[15:8]; mulASgn = 1'b1;
        mulB = regB[15:8]; mulBSgn = 1'b1;
        shiftAmt = 5'd16;
      end
    endcase
  end

  bsmac_mul8 u_mul (
    .aSigned (mulASgn),
    .bSigned (mulBSgn),
    .aByte   (mulA),
    .bByte   (mulB),
    .prod    (prod)
  );

  always_comb begin
    ppExt   = {{(EXT_W - 17){prod[16]}}, prod};
    ppShift = ppExt << shiftAmt;
    addend  = ppShift[ACC_W-1:0];
  end

  bsmac_lane_adder #(.LANES(ACC_BYTES)) u_add (
    .x   (accQ),
    .y   (addend),
    .sum (sumOut)
  );

  assign replace = (strobes.stepIdx == '0) && !modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (clear) begin
      accQ <= '0;
    end else if (strobes.stepValid) begin
      accQ <= replace ? addend : sumOut;
    end
  end

  assign acc = accQ;

endmodule

// File: rtl/byte_serial_mac.sv
module byte_serial_mac
  import bsmac_pkg::*;
#(
  parameter int ACC_BYTES = 5,
  localparam int ACC_W = ACC_BYTES * 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             accumMode,
  input  logic [15:0]      opA,
  input  logic [15:0]      opB,
  input  logic             clear,
  output logic             busy,
  output logic             done,
  output logic [ACC_W-1:0] acc
);

  ctrlStrobes_t strobes;

  bsmac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  bsmac_dpath #(.ACC_BYTES(ACC_BYTES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accumMode (accumMode),
    .opA       (opA),
    .opB       (opB),
    .clear     (clear),
    .acc       (acc)
  );

endmodule

// File: rtl/bsmac_chk.sv
module bsmac_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             clear,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] acc
);

  logic [2:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen <= 3'd3));

  // R3
  done_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runLen == 3'd3) |=> (done && !busy));

  // R4
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && runLen < 3'd3) |=> (busy && runLen != 3'd0));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (acc == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !clear) |=> $stable(acc));

endmodule

bind byte_serial_mac bsmac_chk #(.ACC_W(ACC_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .clear (clear),
  .busy  (busy),
  .done  (done),
  .acc   (acc)
);

// File: tb/byte_serial_mac_tb.sv
`timescale 1ns/1ps
module byte_serial_mac_tb;

  localparam int ACC_BYTES = 5;
  localparam int ACC_W = ACC_BYTES * 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             accumMode = 1'b0;
  logic [15:0]      opA = '0;
  logic [15:0]      opB = '0;
  logic             clear = 1'b0;
  logic             busy;
  logic             done;
  logic [ACC_W-1:0] acc;

  int vecs = 0;
  int errs = 0;
  longint model = 0;

  always #4 clk = ~clk;

  byte_serial_mac #(.ACC_BYTES(ACC_BYTES)) u_dut (
    .clk (clk), .rstN (rstN), .start (start), .accumMode (accumMode),
    .opA (opA), .opB (opB), .clear (clear),
    .busy (busy), .done (done), .acc (acc)
  );

  function automatic logic [ACC_W-1:0] trunc(input longint v);
    logic [63:0] t;
    t = 64'(v);
    return t[ACC_W-1:0];
  endfunction

  function automatic longint fullProd(input logic [15:0] a, input logic [15:0] b);
    longint sa;
    longint sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return sa * sb;
  endfunction

  // Partial product k in the R9 order, computed from the byte definition
  function automatic longint partial(input int k, input logic [15:0] a, input logic [15:0] b);
    longint ah, al, bh, bl;
    ah = longint'($signed(a[15:8]));
    bh = longint'($signed(b[15:8]));
    al = longint'({56'd0, a[7:0]});
    bl = longint'({56'd0, b[7:0]});
    case (k)
      0: return al * bl;
      1: return ah * bl * 256;
      2: return bh * al * 256;
      default: return ah * bh * 65536;
    endcase
  endfunction

  task automatic checkAcc(input string tag, input longint expVal);
    vecs++;
    if (acc !== trunc(expVal)) begin
      errs++;
      $display("FAIL %s: acc actual %h expected %h", tag, acc, trunc(expVal));
    end
  endtask

  task automatic checkBit(input string tag, input logic actual, input logic expected);
    vecs++;
    if (actual !== expected) begin
      errs++;
      $display("FAIL %s: actual %b expected %b", tag, actual, expected);
    end
  endtask

  // One full operation; checks timing (R3) and, if asked, running sums (R9)
  task automatic runOp(input logic [15:0] a, input logic [15:0] b,
                       input logic mode, input bit stepCheck);
    longint base;
    base = mode ? model : 0;
    @(negedge clk);
    start = 1'b1; opA = a; opB = b; accumMode = mode;
    @(negedge clk);
    start = 1'b0;
    if (stepCheck) checkBit("R3 busy after start", busy, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      base = base + partial(k, a, b);
      if (stepCheck) begin
        checkAcc($sformatf("R9 running sum step %0d", k), base);
        checkBit("R3 busy/done step", done, (k == 3));
      end
    end
    if (stepCheck) checkBit("R3 busy low at done", busy, 1'b0);
    model = mode ? model + fullProd(a, b) : fullProd(a, b);
    @(negedge clk);
    if (stepCheck) checkBit("R3 done single pulse", done, 1'b0);
  endtask

  task automatic testReset();
    checkAcc("R7 reset acc", 0);
    checkBit("R3 reset busy", busy, 1'b0);
    checkBit("R3 reset done", done, 1'b0);
  endtask

  task automatic testMulOnly();
    runOp(16'h1234, 16'h5678, 1'b0, 1'b1);
    checkAcc("R1 mul-only pos", model);
    runOp(16'hF00D, 16'h00FF, 1'b0, 1'b1);
    checkAcc("R1 mul-only mixed sign", model);
    runOp(16'h8001, 16'hFFFF, 1'b0, 1'b1);
    checkAcc("R1 mul-only replaces", fullProd(16'h8001, 16'hFFFF));
    runOp(16'h00FF, 16'h00FF, 1'b0, 1'b1);
    checkAcc("R9 low bytes unsigned", 65025);
  endtask

  task automatic testMac();
    runOp(16'd300, 16'hFF38, 1'b0, 1'b0);
    runOp(16'h7FFF, 16'h7FFF, 1'b1, 1'b1);
    checkAcc("R2 accumulate 1", model);
    runOp(16'hABCD, 16'h1357, 1'b1, 1'b0);
    checkAcc("R2 accumulate 2", model);
    runOp(16'h0080, 16'h8080, 1'b1, 1'b1);
    checkAcc("R2 accumulate 3", model);
  endtask

  task automatic testMostNeg();
    runOp(16'h8000, 16'h8000, 1'b0, 1'b1);
    checkAcc("R8 min x min", 64'sd1073741824);
    runOp(16'h8000, 16'h7FFF, 1'b0, 1'b1);
    checkAcc("R8 min x max", -64'sd1073709056);
  endtask

  task automatic testStartIgnored();
    longint keep;
    runOp(16'd7, 16'd9, 1'b0, 1'b0);
    keep = model;
    @(negedge clk);
    start = 1'b1; opA = 16'd100; opB = 16'd3; accumMode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; opA = 16'h4000; opB = 16'h4000; accumMode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkBit("R4 done on schedule", done, 1'b1);
    checkAcc("R4 busy start ignored", 300);
    @(negedge clk);
    @(negedge clk);
    checkBit("R4 no extra op busy", busy, 1'b0);
    checkAcc("R4 acc unchanged after", 300);
    checkAcc("R7 idle hold", 300);
    model = 300;
    if (keep == 0) errs++;
  endtask

  task automatic testClearCollide();
    runOp(16'd1000, 16'd1000, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; opA = 16'd5; opB = 16'd5; accumMode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    checkAcc("R5 clear beats final step", 0);
    checkBit("R5 done still pulses", done, 1'b1);
    model = 0;
    // clear together with an accepted start, accumulate mode
    runOp(16'd50, 16'd60, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; clear = 1'b1; opA = 16'hFFFE; opB = 16'd1234; accumMode = 1'b1;
    @(negedge clk);
    start = 1'b0; clear = 1'b0;
    checkAcc("R5 clear with start", 0);
    repeat (4) @(negedge clk);
    checkAcc("R5 clear then product", fullProd(16'hFFFE, 16'd1234));
    model = fullProd(16'hFFFE, 16'd1234);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    checkAcc("R5 idle clear", 0);
    model = 0;
  endtask

  task automatic testWrap();
    runOp(16'h8000, 16'h8000, 1'b0, 1'b0);
    for (int i = 1; i < 600; i++) runOp(16'h8000, 16'h8000, 1'b1, 1'b0);
    checkAcc("R6 wrap modulo", model);
    checkBit("R6 sign bit wrapped, no saturation", acc[ACC_W-1], 1'b1);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testMulOnly();
    testMac();
    testMostNeg();
    testStartIgnored();
    testClearCollide();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule